// File: doc/BRIEF.md
# Packed Uniform Vector Write Unpacker

This block listens to a command register bus and turns streams of 32-bit data writes into four-component vectors of 24-bit floats stored in a uniform memory of 96 entries. Eight neighbouring bus addresses feed the same data input. Each accepted word goes into a small staging buffer. Once enough words for one vector have arrived, the block issues a single memory write. It then steps its own destination index so that the next vector fills the next entry.

A setup register, written through the same bus, holds two things: an input mode bit and the destination index. In full-precision mode each word is one IEEE single-precision value, and the block narrows it to the 24-bit format. In packed mode, three words carry four 24-bit values end to end, with the fields crossing word boundaries. In both modes the first value written becomes the highest component (w), and the last value written becomes x.

Top module: `uvec_unpacker`

## Requirements
- R1: A bus write to any address from 0x2C1 to 0x2C8 is taken as one data word. Bus writes to any other address except the setup address 0x2C0 change nothing. In particular they do not advance the word count.
- R2: With the mode bit clear (packed mode), the third data word completes a vector. For words p0, p1, p2 the stored components are w = p0[31:8], z = {p0[7:0], p1[31:16]}, y = {p1[15:0], p2[31:24]} and x = p2[23:0].
- R3: With the mode bit set (single-precision mode), the fourth data word completes a vector. The converted word i lands in component 3-i, so the first word goes to w and the fourth to x.
- R4: A single-precision word is narrowed to 24 bits: sign, 7-bit exponent with bias 63, and 16 mantissa bits truncated from the top of the 23. A source exponent field of 64 or less yields a signed zero. A source exponent field of 192 or more clamps the exponent to 127.
- R5: Each completed vector with a valid index gives exactly one cycle of `mem_we`, in the cycle after the completing bus write. mem_data is laid out with w in [95:72], z in [71:48], y in [47:24] and x in [23:0].
- R6: After a stored vector, the index in the setup register (seen on `cfg_index`) rises by one.
- R7: If a vector completes while the index is above 95, nothing is written, the index stays as it is, and `err` rises and stays high until reset. The word count still returns to zero.
- R8: A write to setup address 0x2C0 loads the mode from data bit 31 and the index from data bits [6:0]. It also throws away any partially gathered vector.
- R9: A synchronous reset clears the word count, the staging buffer, `err`, `mem_we`, the mode and the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 12 | Bus register address |
| bus_data | input | 32 | Bus write data |
| cfg_fp32 | output | 1 | Current mode, 1 = single-precision |
| cfg_index | output | 7 | Current destination index |
| mem_we | output | 1 | Uniform memory write strobe |
| mem_idx | output | 7 | Uniform memory entry |
| mem_data | output | 96 | Vector {w,z,y,x} |
| err | output | 1 | Sticky out-of-range index flag |

## Verification
A word count that slips by one makes a strobe arrive one word early or late. It also shifts every field of the vector, so the first vector after the fault shows the error on `mem_data`, or shows a strobe where none was expected. A wrong index register shows up on `cfg_index` in the cycle after the vector is stored. A wrong conversion or component order shows up in the data of that same strobe.

// File: rtl/uvu_pkg.sv
package uvu_pkg;
    localparam int WORD_W   = 32;
    localparam int F24_W    = 24;
    localparam int COMP_N   = 4;
    localparam int VEC_W    = COMP_N * F24_W;
    localparam int EXP8_W   = 8;
    localparam int EXP7_W   = 7;
    localparam int MAN_W    = 16;
    // single-precision bias 127 minus narrow bias 63
    localparam int EXP_SHIFT = 64;

    typedef enum logic {
        MODE_PACKED = 1'b0,
        MODE_FP32   = 1'b1
    } mode_e;
endpackage

// File: rtl/uvu_addr_dec.sv
module uvu_addr_dec #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] SETUP_ADDR = 12'h2C0,
    parameter logic [ADDR_W-1:0] DATA_BASE = 12'h2C1,
    parameter int DATA_ALIASES = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              setup_hit,
    output logic              data_hit
);
    localparam logic [ADDR_W-1:0] DATA_END = ADDR_W'(DATA_BASE + DATA_ALIASES);

    always_comb begin
        setup_hit = bus_wr && (bus_addr == SETUP_ADDR);
        data_hit  = bus_wr && (bus_addr >= DATA_BASE) && (bus_addr < DATA_END);
    end
endmodule

// File: rtl/uvu_fconv.sv
module uvu_fconv
    import uvu_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [F24_W-1:0]  f24_o
);
    localparam logic [EXP8_W-1:0] UNDER_LIM = EXP8_W'(EXP_SHIFT);
    localparam logic [EXP8_W-1:0] OVER_LIM  = EXP8_W'(EXP_SHIFT + (1 << EXP7_W));

    logic              sgn;
    logic [EXP8_W-1:0] exp_in;
    logic [EXP8_W-1:0] exp_rb;
    logic [EXP7_W-1:0] exp_out;

    always_comb begin
        sgn     = word_i[WORD_W-1];
        exp_in  = word_i[WORD_W-2 -: EXP8_W];
        exp_rb  = exp_in - UNDER_LIM;
        exp_out = exp_rb[EXP7_W-1:0];
        if (exp_in <= UNDER_LIM) begin
            f24_o = {sgn, {(F24_W-1){1'b0}}};
        end else if (exp_in >= OVER_LIM) begin
            f24_o = {sgn, {EXP7_W{1'b1}}, word_i[WORD_W-2-EXP8_W -: MAN_W]};
        end else begin
            f24_o = {sgn, exp_out, word_i[WORD_W-2-EXP8_W -: MAN_W]};
        end
    end
endmodule

// File: rtl/uvu_pack24.sv
module uvu_pack24
    import uvu_pkg::*;
(
    input  logic [WORD_W-1:0] p0,
    input  logic [WORD_W-1:0] p1,
    input  logic [WORD_W-1:0] p2,
    output logic [VEC_W-1:0]  vec_o
);
    logic [F24_W-1:0] cx, cy, cz, cw;

    always_comb begin
        cw    = p0[31:8];
        cz    = {p0[7:0], p1[31:16]};
        cy    = {p1[15:0], p2[31:24]};
        cx    = p2[23:0];
        vec_o = {cw, cz, cy, cx};
    end
endmodule

// File: rtl/uvec_unpacker.sv
module uvec_unpacker
    import uvu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] SETUP_ADDR = 12'h2C0,
    parameter logic [ADDR_W-1:0] DATA_BASE = 12'h2C1,
    parameter int DATA_ALIASES = 8,
    parameter int IDX_W = 7,
    parameter int NUM_ENTRIES = 96,
    parameter int MODE_BIT = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_data,
    output logic               cfg_fp32,
    output logic [IDX_W-1:0]   cfg_index,
    output logic               mem_we,
    output logic [IDX_W-1:0]   mem_idx,
    output logic [95:0]        mem_data,
    output logic               err
);
    localparam int STAGE_N = COMP_N - 1;
    localparam int CNT_W = $clog2(COMP_N);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
    localparam logic [CNT_W-1:0] LAST_FP32 = CNT_W'(COMP_N - 1);
    localparam logic [CNT_W-1:0] LAST_PACK = CNT_W'(STAGE_N - 1);

    typedef struct packed {
        mode_e                          mode;
        logic [IDX_W-1:0]               idx;
        logic [CNT_W-1:0]               cnt;
        logic [STAGE_N-1:0][WORD_W-1:0] stage;
        logic                           we;
        logic [IDX_W-1:0]               widx;
        logic [VEC_W-1:0]               wdata;
        logic                           err;
    } state_t;

    state_t s_d, s_q;

    logic setup_hit, data_hit;
    logic [VEC_W-1:0] pack_vec, fp32_vec;
    logic [COMP_N-1:0][WORD_W-1:0] conv_in;

    uvu_addr_dec #(
        .ADDR_W(ADDR_W), .SETUP_ADDR(SETUP_ADDR),
        .DATA_BASE(DATA_BASE), .DATA_ALIASES(DATA_ALIASES)
    ) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .setup_hit(setup_hit), .data_hit(data_hit)
    );

    uvu_pack24 u_pack (
        .p0(s_q.stage[0]), .p1(s_q.stage[1]), .p2(bus_data), .vec_o(pack_vec)
    );

    // word i of the vector feeds component 3-i; the live bus word is the last
    genvar gi;
    generate
        for (gi = 0; gi < COMP_N; gi++) begin : g_conv
            if (gi < STAGE_N) begin : g_staged
                assign conv_in[gi] = s_q.stage[gi];
            end else begin : g_live
                assign conv_in[gi] = bus_data;
            end
            uvu_fconv u_fc (
                .word_i(conv_in[gi]),
                .f24_o(fp32_vec[VEC_W-1-gi*F24_W -: F24_W])
            );
        end
    endgenerate

    always_comb begin
        logic last;
        s_d    = s_q;
        s_d.we = 1'b0;
        last   = (s_q.mode == MODE_FP32) ? (s_q.cnt == LAST_FP32)
                                         : (s_q.cnt == LAST_PACK);
        if (setup_hit) begin
            s_d.mode = mode_e'(bus_data[MODE_BIT]);
            s_d.idx  = bus_data[IDX_W-1:0];
            s_d.cnt  = '0;
        end else if (data_hit) begin
            if (!last) begin
                s_d.stage[s_q.cnt] = bus_data;
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end else begin
                s_d.cnt = '0;
                if (s_q.idx <= LAST_IDX) begin
                    s_d.we    = 1'b1;
                    s_d.widx  = s_q.idx;
                    s_d.wdata = (s_q.mode == MODE_FP32) ? fp32_vec : pack_vec;
                    s_d.idx   = s_q.idx + IDX_W'(1);
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cfg_fp32  = (s_q.mode == MODE_FP32);
    assign cfg_index = s_q.idx;
    assign mem_we    = s_q.we;
    assign mem_idx   = s_q.widx;
    assign mem_data  = s_q.wdata;
    assign err       = s_q.err;
endmodule

// File: rtl/uvec_unpacker_chk.sv
module uvec_unpacker_chk #(
    parameter int IDX_W = 7,
    parameter int NUM_ENTRIES = 96
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_idx,
    input logic [IDX_W-1:0] cfg_index,
    input logic             err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r5_needs_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(bus_wr));

    a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cfg_index == mem_idx + IDX_W'(1)));

    a_r7_valid_entry: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_idx <= LAST_IDX));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!mem_we && !err));
endmodule

bind uvec_unpacker uvec_unpacker_chk #(.IDX_W(IDX_W), .NUM_ENTRIES(NUM_ENTRIES)) u_chk (.*);

// File: tb/tb_uvec_unpacker.sv
module tb_uvec_unpacker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        cfg_fp32;
    logic [6:0]  cfg_index;
    logic        mem_we;
    logic [6:0]  mem_idx;
    logic [95:0] mem_data;
    logic        err;

    int nchk = 0;
    int nbad = 0;
    int pushed = 0;
    int seen = 0;
    bit done = 0;
    bit prev_we = 0;

    logic [102:0] exp_q[$];
    string        tag_q[$];

    always #5 clk = ~clk;

    uvec_unpacker dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .cfg_fp32(cfg_fp32), .cfg_index(cfg_index),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_data(mem_data), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic bus(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic setup(input bit fp32, input logic [6:0] idx);
        bus(12'h2C0, {fp32, 24'd0, idx});
    endtask

    task automatic expect_vec(input string req, input logic [6:0] idx,
                              input logic [23:0] w, input logic [23:0] z,
                              input logic [23:0] y, input logic [23:0] x);
        exp_q.push_back({idx, w, z, y, x});
        tag_q.push_back(req);
        pushed++;
    endtask

    // monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            seen++;
            nchk++;
            if (prev_we) begin
                nbad++;
                $display("FAIL R5 strobe longer than one cycle act=1 exp=0");
            end else if (exp_q.size() == 0) begin
                nbad++;
                $display("FAIL R1/R8 unexpected strobe idx=%0d data=%h exp=none", mem_idx, mem_data);
            end else begin
                logic [102:0] it;
                string t;
                it = exp_q.pop_front();
                t  = tag_q.pop_front();
                if ({mem_idx, mem_data} !== it) begin
                    nbad++;
                    $display("FAIL %s act=%h exp=%h", t, {mem_idx, mem_data}, it);
                end
            end
        end
        prev_we = mem_we && !rst;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 mem_we", 32'(mem_we), 32'd0);
        check("R9 err", 32'(err), 32'd0);
        check("R9 index", 32'(cfg_index), 32'd0);
        check("R9 mode", 32'(cfg_fp32), 32'd0);

        // R8: setup load, packed mode, index 0
        setup(1'b0, 7'd0);
        check("R8 mode", 32'(cfg_fp32), 32'd0);
        check("R8 index", 32'(cfg_index), 32'd0);

        // R2: packed unpack across aliases
        expect_vec("R2 packed", 7'd0, 24'h112233, 24'h445566, 24'h778899, 24'hAABBCC);
        bus(12'h2C1, 32'h11223344);
        bus(12'h2C8, 32'h55667788);
        bus(12'h2C4, 32'h99AABBCC);
        check("R6 index after store", 32'(cfg_index), 32'd1);

        // R1: writes outside the alias window are ignored
        expect_vec("R1 ignored addr", 7'd1, 24'hDEADBE, 24'hEF0123, 24'h456789, 24'hABCDEF);
        bus(12'h2C1, 32'hDEADBEEF);
        bus(12'h2C9, 32'hFFFFFFFF);
        bus(12'h2BF, 32'hFFFFFFFF);
        bus(12'h2C2, 32'h01234567);
        bus(12'h2C9, 32'h00000000);
        check("R1 no early strobe", 32'(seen), 32'd1);
        bus(12'h2C3, 32'h89ABCDEF);
        check("R1 index", 32'(cfg_index), 32'd2);

        // R3: single-precision mode, reversed order
        setup(1'b1, 7'd20);
        check("R8 mode fp32", 32'(cfg_fp32), 32'd1);
        expect_vec("R3 fp32 order", 7'd20, 24'h3F0000, 24'h404000, 24'hBE0000, 24'h000000);
        bus(12'h2C5, 32'h3F800000);
        bus(12'h2C6, 32'h40200000);
        bus(12'h2C7, 32'hBF000000);
        bus(12'h2C2, 32'h00000000);

        // R4: clamp, underflow, truncation, negative zero
        expect_vec("R4 convert", 7'd21, 24'h7F0000, 24'h000000, 24'h3F0001, 24'h800000);
        bus(12'h2C1, 32'h7F000000);
        bus(12'h2C1, 32'h20000000);
        bus(12'h2C1, 32'h3F800081);
        bus(12'h2C1, 32'h80000000);
        check("R6 index", 32'(cfg_index), 32'd22);

        // R8: partial vector discarded by setup write
        setup(1'b0, 7'd10);
        bus(12'h2C1, 32'hAAAAAAAA);
        bus(12'h2C1, 32'hBBBBBBBB);
        setup(1'b1, 7'd10);
        expect_vec("R8 discard", 7'd10, 24'h3F0000, 24'h3F0000, 24'h3F0000, 24'h3F0000);
        bus(12'h2C1, 32'h3F800000);
        bus(12'h2C1, 32'h3F800000);
        bus(12'h2C1, 32'h3F800000);
        check("R8 no strobe at 3 words", 32'(seen), 32'd4);
        bus(12'h2C1, 32'h3F800000);

        // R7: last valid entry then out of range
        setup(1'b0, 7'd95);
        expect_vec("R7 entry 95", 7'd95, 24'h010203, 24'h040506, 24'h070809, 24'h0A0B0C);
        bus(12'h2C1, 32'h01020304);
        bus(12'h2C1, 32'h05060708);
        bus(12'h2C1, 32'h090A0B0C);
        check("R7 index 96", 32'(cfg_index), 32'd96);
        check("R7 err low", 32'(err), 32'd0);
        bus(12'h2C1, 32'h1);
        bus(12'h2C1, 32'h2);
        bus(12'h2C1, 32'h3);
        @(negedge clk);
        check("R7 err set", 32'(err), 32'd1);
        check("R7 index held", 32'(cfg_index), 32'd96);
        check("R7 no write", 32'(seen), 32'd6);

        setup(1'b0, 7'd2);
        expect_vec("R7 recover", 7'd2, 24'hCAFEF0, 24'h0D1234, 24'h567890, 24'h123456);
        bus(12'h2C1, 32'hCAFEF00D);
        bus(12'h2C1, 32'h12345678);
        bus(12'h2C1, 32'h90123456);
        check("R7 err sticky", 32'(err), 32'd1);

        repeat (3) @(negedge clk);
        check("R5 strobe count", 32'(seen), 32'(pushed));
        check("R5 queue drained", 32'(exp_q.size()), 32'd0);

        // R9: reset clears err and index
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 err cleared", 32'(err), 32'd0);
        check("R9 index cleared", 32'(cfg_index), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule